// File: doc/BRIEF.md
# Memory Decoder Target Lookup

This block resolves which downstream port owns a host physical address. It holds a bank of address decoders as plain register inputs. Each decoder has a base and a size, built from a high word and the top nibble of a low word. Each also has a control word, with a committed flag and encodings for interleave granularity and ways, and a list of eight 8-bit port numbers packed into two 32-bit words. A capability field sets how many of the decoders take part in the search.

A pulse on `startI` captures the address and the decoder count. The block then visits one decoder per clock, from index 0 upward. The first decoder whose range contains the address ends the search. If that decoder is committed, the block picks a list slot with interleave arithmetic and returns the port number stored there. If it is not committed, the result is a miss and no later decoder is looked at. If no range contains the address, the result is also a miss. `doneO` pulses for one cycle when the result is ready. `foundO` and `targetO` then hold until the next accepted start.

Top module: `hdm_lookup`

## Requirements
- R1: The number of decoders searched is 1 when `capCountI` is 0 and twice `capCountI` otherwise, limited to `NUM_DEC`. Decoders at or above that count never match.
- R2: A decoder's base is `{baseHi, baseLo[31:28], 28'b0}` and its size is `{sizeHi, sizeLo[31:28], 28'b0}`. Bits 27:0 of the low words have no effect.
- R3: A decoder matches when base <= address < base + size, computed without overflow. Decoders are visited in ascending index order and the first match ends the search.
- R4: If the first matching decoder has control bit 10 (committed) clear, the result is a miss (`foundO`=0). No later decoder is examined.
- R5: For a committed match, the slot is (address >> (8 + g)) mod 2^w. Here g is control bits 3:0 and w is control bits 7:4, and values of w above 3 act as 3.
- R6: Slots 0 to 3 take bytes 0 to 3 (byte k at bits 8k+7:8k) of the low list word. Slots 4 to 7 take bytes 0 to 3 of the high list word. The selected byte appears on `targetO` with `foundO`=1.
- R7: If no searched decoder contains the address, the result is a miss. On every miss `targetO` is 0.
- R8: One decoder is examined per clock. The cycle in which start is sampled is cycle 0. `doneO` is high in cycle d+1, where d is the deciding decoder index: the matching one, or the last one searched on a miss.
- R9: `doneO` is high for exactly one cycle per search. `foundO` and `targetO` change only when `doneO` rises or just after an accepted start, which clears them to 0.
- R10: A start pulse during a search in progress is ignored. The running search completes with its original address.
- R11: After reset `doneO`, `foundO` and `targetO` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Begin a lookup (accepted when idle) |
| addrI | input | 64 | Host physical address to resolve |
| capCountI | input | 4 | Encoded decoder count |
| baseLoI | input | NUM_DEC×32 | Low base words, bits 31:28 used |
| baseHiI | input | NUM_DEC×32 | High base words |
| sizeLoI | input | NUM_DEC×32 | Low size words, bits 31:28 used |
| sizeHiI | input | NUM_DEC×32 | High size words |
| ctrlI | input | NUM_DEC×32 | Control words: granularity, ways, committed |
| listLoI | input | NUM_DEC×32 | Port numbers for slots 0 to 3 |
| listHiI | input | NUM_DEC×32 | Port numbers for slots 4 to 7 |
| doneO | output | 1 | One-cycle result strobe |
| foundO | output | 1 | Lookup hit on a committed decoder |
| targetO | output | 8 | Selected downstream port number |

## Verification
The bench builds the block with `NUM_DEC` = 4. With that value a count field of 3 (six decoders) is clamped, and a full miss reaches the last decoder in a few cycles. The small bank lets the bench sweep every granularity from 0 to 3 against every ways encoding from 0 to 4, over ten successive interleave chunks. That covers both list words and the ways clamp. Overlapping decoders expose the uncommitted-first-match rule. Ranges placed at the window edges and count fields of 0, 1 and 3 probe the boundaries.

// File: rtl/hdm_lookup_pkg.sv
package hdm_lookup_pkg;
  localparam int ADDR_W        = 64;
  localparam int WORD_W        = 32;
  localparam int PORT_W        = 8;
  localparam int CHUNK_LSB     = 28;
  localparam int FIELD_W       = 4;
  localparam int GRAN_LSB      = 0;
  localparam int WAYS_LSB      = 4;
  localparam int COMMIT_BIT    = 10;
  localparam int MIN_GRAN_LOG2 = 8;
  localparam int MAX_WAYS_ENC  = 3;
  localparam int SLOT_W        = 3;

  typedef struct packed {
    logic clear;
    logic step;
    logic finishHit;
    logic finishMiss;
  } seqCmd_t;

  typedef enum logic [0:0] {ST_IDLE, ST_SCAN} seqState_t;
endpackage

// File: rtl/hdm_lookup_dp.sv
module hdm_lookup_dp
  import hdm_lookup_pkg::*;
#(
  parameter int NUM_DEC = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  seqCmd_t                            cmd,
  input  logic [ADDR_W-1:0]                  addrI,
  input  logic [FIELD_W-1:0]                 capCountI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     baseLoI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     baseHiI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     sizeLoI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     sizeHiI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     ctrlI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     listLoI,
  input  logic [NUM_DEC-1:0][WORD_W-1:0]     listHiI,
  output logic                               hitO,
  output logic                               lastO,
  output logic                               foundO,
  output logic [PORT_W-1:0]                  targetO
);
  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;
  localparam int LOW_KEEP = WORD_W - CHUNK_LSB;

  logic [IDX_W-1:0]  idxQ, lastQ, lastNext;
  logic [ADDR_W-1:0] addrQ;
  logic              foundQ;
  logic [PORT_W-1:0] targetQ;

  logic [NUM_DEC-1:0][ADDR_W-1:0] baseVec;
  logic [NUM_DEC-1:0][ADDR_W-1:0] sizeVec;

  // Assemble each decoder's window words; low chunk bits are forced to zero.
  for (genvar g = 0; g < NUM_DEC; g++) begin : g_win
    assign baseVec[g] = {baseHiI[g], baseLoI[g][WORD_W-1 -: LOW_KEEP], {CHUNK_LSB{1'b0}}};
    assign sizeVec[g] = {sizeHiI[g], sizeLoI[g][WORD_W-1 -: LOW_KEEP], {CHUNK_LSB{1'b0}}};
  end

  // Count decode: 0 -> one decoder, n -> 2n decoders, clamped to the bank.
  int decCount;
  always_comb begin
    decCount = (capCountI == '0) ? 1 : 2 * int'(capCountI);
    if (decCount > NUM_DEC) decCount = NUM_DEC;
    lastNext = IDX_W'(decCount - 1);
  end

  // Range test for the decoder under examination.
  logic [ADDR_W-1:0] baseCur, sizeCur;
  logic [ADDR_W:0]   limitCur;
  assign baseCur  = baseVec[idxQ];
  assign sizeCur  = sizeVec[idxQ];
  assign limitCur = {1'b0, baseCur} + {1'b0, sizeCur};
  assign hitO     = ({1'b0, addrQ} >= {1'b0, baseCur}) && ({1'b0, addrQ} < limitCur);
  assign lastO    = (idxQ == lastQ);

  // Interleave slot selection.
  logic [WORD_W-1:0]   ctrlCur;
  logic [FIELD_W-1:0]  granEnc, waysEnc;
  logic [1:0]          waysEff;
  logic [ADDR_W-1:0]   chunkIdx;
  logic [SLOT_W-1:0]   slotMask, slot;
  logic [2*WORD_W-1:0] listCat;
  logic [PORT_W-1:0]   portSel;
  logic                committed;

  always_comb begin
    ctrlCur   = ctrlI[idxQ];
    granEnc   = ctrlCur[GRAN_LSB +: FIELD_W];
    waysEnc   = ctrlCur[WAYS_LSB +: FIELD_W];
    committed = ctrlCur[COMMIT_BIT];
    waysEff   = (int'(waysEnc) > MAX_WAYS_ENC) ? 2'(MAX_WAYS_ENC) : waysEnc[1:0];
    chunkIdx  = addrQ >> (MIN_GRAN_LOG2 + int'(granEnc));
    slotMask  = SLOT_W'((1 << waysEff) - 1);
    slot      = chunkIdx[SLOT_W-1:0] & slotMask;
    listCat   = {listHiI[idxQ], listLoI[idxQ]};
    portSel   = listCat[{slot, 3'b000} +: PORT_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= '0;
      lastQ   <= '0;
      addrQ   <= '0;
      foundQ  <= 1'b0;
      targetQ <= '0;
    end else begin
      if (cmd.clear) begin
        idxQ    <= '0;
        lastQ   <= lastNext;
        addrQ   <= addrI;
        foundQ  <= 1'b0;
        targetQ <= '0;
      end else if (cmd.step) begin
        idxQ <= idxQ + 1'b1;
      end
      if (cmd.finishHit) begin
        foundQ  <= committed;
        targetQ <= committed ? portSel : '0;
      end else if (cmd.finishMiss) begin
        foundQ  <= 1'b0;
        targetQ <= '0;
      end
    end
  end

  assign foundO  = foundQ;
  assign targetO = targetQ;
endmodule

// File: rtl/hdm_lookup_ctrl.sv
module hdm_lookup_ctrl
  import hdm_lookup_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startI,
  input  logic    hitI,
  input  logic    lastI,
  output seqCmd_t cmd,
  output logic    doneO
);
  seqState_t stateQ, stateNext;
  logic      doneQ;

  always_comb begin
    cmd       = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (startI) begin
          cmd.clear = 1'b1;
          stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (hitI) begin
          cmd.finishHit = 1'b1;
          stateNext     = ST_IDLE;
        end else if (lastI) begin
          cmd.finishMiss = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          cmd.step = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= cmd.finishHit | cmd.finishMiss;
    end
  end

  assign doneO = doneQ;
endmodule

// File: rtl/hdm_lookup.sv
module hdm_lookup
  import hdm_lookup_pkg::*;
#(
  parameter int NUM_DEC = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           startI,
  input  logic [63:0]                    addrI,
  input  logic [3:0]                     capCountI,
  input  logic [NUM_DEC-1:0][31:0]       baseLoI,
  input  logic [NUM_DEC-1:0][31:0]       baseHiI,
  input  logic [NUM_DEC-1:0][31:0]       sizeLoI,
  input  logic [NUM_DEC-1:0][31:0]       sizeHiI,
  input  logic [NUM_DEC-1:0][31:0]       ctrlI,
  input  logic [NUM_DEC-1:0][31:0]       listLoI,
  input  logic [NUM_DEC-1:0][31:0]       listHiI,
  output logic                           doneO,
  output logic                           foundO,
  output logic [7:0]                     targetO
);
  seqCmd_t cmd;
  logic    hit, last;

  hdm_lookup_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .startI(startI),
    .hitI  (hit),
    .lastI (last),
    .cmd   (cmd),
    .doneO (doneO)
  );

  hdm_lookup_dp #(.NUM_DEC(NUM_DEC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .addrI    (addrI),
    .capCountI(capCountI),
    .baseLoI  (baseLoI),
    .baseHiI  (baseHiI),
    .sizeLoI  (sizeLoI),
    .sizeHiI  (sizeHiI),
    .ctrlI    (ctrlI),
    .listLoI  (listLoI),
    .listHiI  (listHiI),
    .hitO     (hit),
    .lastO    (last),
    .foundO   (foundO),
    .targetO  (targetO)
  );
endmodule

// File: rtl/hdm_lookup_checker.sv
module hdm_lookup_checker #(
  parameter int NUM_DEC = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       startI,
  input logic       doneO,
  input logic       foundO,
  input logic [7:0] targetO
);
  logic busyQ;
  int   cycQ;

  // Track an accepted search and how long it has been running.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cycQ  <= 0;
    end else if (busyQ && doneO) begin
      busyQ <= startI;
      cycQ  <= 0;
    end else if (busyQ) begin
      cycQ <= cycQ + 1;
    end else if (startI) begin
      busyQ <= 1'b1;
      cycQ  <= 0;
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({foundO, targetO}) |-> (doneO || $past(startI)));

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !foundO) |-> (targetO == 8'd0));

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> busyQ);

  a_r8_scan_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cycQ <= NUM_DEC));
endmodule

bind hdm_lookup hdm_lookup_checker #(.NUM_DEC(NUM_DEC)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .startI (startI),
  .doneO  (doneO),
  .foundO (foundO),
  .targetO(targetO)
);

// File: tb/hdm_lookup_bench.sv
module hdm_lookup_bench;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startI = 1'b0;
  logic [63:0] addrI = '0;
  logic [3:0] capCountI = 4'd2;
  logic [ND-1:0][31:0] bl, bh, sl, sh, ctl, ll, lh;
  logic doneO, foundO;
  logic [7:0] targetO;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  hdm_lookup #(.NUM_DEC(ND)) u_hdm_lookup (
    .clk(clk), .rstN(rstN), .startI(startI), .addrI(addrI), .capCountI(capCountI),
    .baseLoI(bl), .baseHiI(bh), .sizeLoI(sl), .sizeHiI(sh), .ctrlI(ctl),
    .listLoI(ll), .listHiI(lh), .doneO(doneO), .foundO(foundO), .targetO(targetO)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Model built from the requirements: returns result and deciding index.
  function automatic void refLook(input logic [63:0] a, input logic [3:0] fld,
                                  output bit f, output logic [7:0] t, output int dec);
    int n;
    logic [63:0] base, size;
    int g, w, slot;
    n = (fld == 0) ? 1 : 2 * int'(fld);
    if (n > ND) n = ND;
    f = 0; t = 8'd0; dec = n - 1;
    for (int i = 0; i < n; i++) begin
      base = {bh[i], bl[i][31:28], 28'h0};
      size = {sh[i], sl[i][31:28], 28'h0};
      if (a >= base && {1'b0, a} < ({1'b0, base} + {1'b0, size})) begin
        dec = i;
        if (ctl[i][10]) begin
          g = int'(ctl[i][3:0]);
          w = int'(ctl[i][7:4]);
          if (w > 3) w = 3;
          slot = int'((a >> (8 + g)) % (64'd1 << w));
          t = (slot < 4) ? ll[i][slot*8 +: 8] : lh[i][(slot-4)*8 +: 8];
          f = 1;
        end
        return;
      end
    end
  endfunction

  // Latency counts negedges after the start edge; done in cycle d+1 shows at d+2.
  task automatic lookup(input logic [63:0] a, input bit extraStart, input logic [63:0] a2,
                        output bit f, output logic [7:0] t, output int lat);
    addrI = a;
    startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    lat = 1;
    if (extraStart) begin
      addrI = a2;
      startI = 1'b1;
    end
    while (!doneO && lat < 40) begin
      @(negedge clk);
      startI = 1'b0;
      lat++;
    end
    f = foundO;
    t = targetO;
  endtask

  task automatic runCheck(input string req, input logic [63:0] a);
    bit f, ef;
    logic [7:0] t, et;
    int lat, dec;
    refLook(a, capCountI, ef, et, dec);
    lookup(a, 1'b0, 64'd0, f, t, lat);
    chk({req, " found"}, 64'(f), 64'(ef));
    chk({req, " target"}, 64'(t), 64'(et));
    chk({req, " R8 latency"}, 64'(lat), 64'(dec + 2));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit f, f0;
    logic [7:0] t, t0;
    int lat;
    // Decoder 0: committed, junk in low bits of base/size low words (R2).
    bl[0] = 32'h0ABC_DEF0; bh[0] = 32'h1; sl[0] = 32'h1FFF_FFFF; sh[0] = 32'h0;
    ctl[0] = 32'h400; ll[0] = 32'h1312_1110; lh[0] = 32'h1716_1514;
    // Decoder 1: uncommitted, 512 MiB at 0x2_0000_0000.
    bl[1] = 32'h0; bh[1] = 32'h2; sl[1] = 32'h2000_0000; sh[1] = 32'h0;
    ctl[1] = 32'h0; ll[1] = 32'h2322_2120; lh[1] = 32'h2726_2524;
    // Decoder 2: committed, shadowed by decoder 1.
    bl[2] = 32'h0; bh[2] = 32'h2; sl[2] = 32'h1000_0000; sh[2] = 32'h0;
    ctl[2] = 32'h400; ll[2] = 32'h3332_3130; lh[2] = 32'h3736_3534;
    // Decoder 3: committed, two ways, 1 KiB granularity.
    bl[3] = 32'h0; bh[3] = 32'h3; sl[3] = 32'h1000_0000; sh[3] = 32'h0;
    ctl[3] = 32'h412; ll[3] = 32'h0000_2B2A; lh[3] = 32'h0;

    repeat (3) @(negedge clk);
    chk("R11 done", 64'(doneO), 64'd0);
    chk("R11 found", 64'(foundO), 64'd0);
    chk("R11 target", 64'(targetO), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R5/R6 sweep over granularity, ways and successive chunks of decoder 0.
    for (int g = 0; g < 4; g++) begin
      for (int w = 0; w < 5; w++) begin
        ctl[0] = 32'h400 | 32'(w << 4) | 32'(g);
        for (int k = 0; k < 10; k++) begin
          runCheck("R5/R6 sweep", 64'h1_0000_0000 + 64'(k * (256 << g)) + 64'd5);
        end
      end
    end
    ctl[0] = 32'h430;
    // R6 explicit: slot 2 (low word byte 2) and slot 6 (high word byte 2).
    lookup(64'h1_0000_0200, 1'b0, 64'd0, f, t, lat);
    chk("R6 low list byte", 64'(t), 64'h12);
    lookup(64'h1_0000_0600, 1'b0, 64'd0, f, t, lat);
    chk("R6 high list byte", 64'(t), 64'h16);
    // R2: base low bits ignored, so the window begins exactly at 0x1_0000_0000.
    lookup(64'h1_0000_0000, 1'b0, 64'd0, f, t, lat);
    chk("R2 base start", 64'(f), 64'd1);
    runCheck("R2 size end", 64'h1_1000_0000);
    runCheck("R3 below base", 64'h0_FFFF_FFFF);
    // R4: first match uncommitted ends the search before decoder 2.
    lookup(64'h2_0000_0100, 1'b0, 64'd0, f, t, lat);
    chk("R4 found", 64'(f), 64'd0);
    chk("R4 target", 64'(t), 64'd0);
    chk("R4 latency", 64'(lat), 64'd3);
    // R3 boundaries on decoder 3.
    runCheck("R3 last byte", 64'h3_0FFF_FFFF);
    runCheck("R3 first byte", 64'h3_0000_0400);
    // R7: nothing matches, full scan of 4 decoders.
    lookup(64'h3_1000_0000, 1'b0, 64'd0, f, t, lat);
    chk("R7 found", 64'(f), 64'd0);
    chk("R7 target", 64'(t), 64'd0);
    chk("R7 R8 latency", 64'(lat), 64'd5);
    runCheck("R7 zero address", 64'h0);
    // R1: count field decode.
    capCountI = 4'd1;
    lookup(64'h3_0000_0000, 1'b0, 64'd0, f, t, lat);
    chk("R1 two decoders found", 64'(f), 64'd0);
    chk("R1 two decoders latency", 64'(lat), 64'd3);
    capCountI = 4'd0;
    lookup(64'h2_0000_0000, 1'b0, 64'd0, f, t, lat);
    chk("R1 one decoder latency", 64'(lat), 64'd2);
    capCountI = 4'd3;
    runCheck("R1 clamped count", 64'h3_0000_0400);
    capCountI = 4'd2;
    // R9: pulse and hold.
    lookup(64'h1_0000_0300, 1'b0, 64'd0, f0, t0, lat);
    @(negedge clk);
    chk("R9 done pulse", 64'(doneO), 64'd0);
    repeat (3) @(negedge clk);
    chk("R9 found hold", 64'(foundO), 64'(f0));
    chk("R9 target hold", 64'(targetO), 64'(t0));
    chk("R9 target value", 64'(t0), 64'h13);
    // R10: second start during a full-miss scan is ignored.
    lookup(64'h3_2000_0000, 1'b1, 64'h1_0000_0100, f, t, lat);
    chk("R10 found", 64'(f), 64'd0);
    chk("R10 latency", 64'(lat), 64'd5);
    @(negedge clk);
    chk("R10 no second done", 64'(doneO), 64'd0);
    repeat (4) @(negedge clk);
    chk("R10 still idle", 64'(doneO), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule